// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Responder

This block models the responder side of a 128-byte three-wire serial EEPROM. It runs on a system clock and oversamples the select, serial clock and data-in pins. It detects rising edges of the serial clock and decodes each instruction: a start bit, a two-bit opcode and an address. It answers reads on data-out. It also keeps a write-enable latch, a storage array and a programming-busy timer. The parameter `WORD16` sets the organisation: 128 words of 8 bits, or 64 words of 16 bits.

Two build options change the protocol. `SINGLE_READ` makes a read stop after the addressed word; otherwise data keeps streaming through successive addresses while select stays high. `LONG_SPECIAL` makes each special command (opcode 00) need two extra trailing bits before it takes effect.

The controller is a state machine with these states:
- `ST_IDLE` waits for a start bit.
- `ST_OPC` collects the opcode.
- `ST_ADDR` collects the address.
- `ST_TAIL` collects the two extra special bits.
- `ST_WDATA` collects write data.
- `ST_RDATA` shifts out read data.
- `ST_HOLD` ignores clocks until select falls.

Its transitions are:
- `ST_IDLE` goes to `ST_OPC` on a 1 bit while ready.
- `ST_OPC` goes to `ST_ADDR` after two bits.
- After the last address bit, `ST_ADDR` goes to `ST_RDATA`, `ST_WDATA`, `ST_TAIL` or `ST_HOLD`, depending on the opcode and `LONG_SPECIAL`.
- `ST_TAIL` and `ST_WDATA` go to `ST_HOLD` on their last bit.
- Any state returns to `ST_IDLE` when select is low.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, data-out is 0, ready is 1 and the write-enable latch is clear. Data-out is 0 whenever select is low.
- R2: A write (opcode 01) issued while the write-enable latch is clear leaves the array unchanged.
- R3: Each instruction is a 1 start bit, then opcode bits MSB first, then address bits MSB first. Read is opcode 10. A read drives a dummy 0 after the last address bit, then the data MSB first, one bit per serial clock rising edge.
- R4: A write or erase-all that takes effect drops ready for PROG_CYCLES clocks. In `ST_IDLE` with select high, data-out is 0 while busy and 1 once ready. Start bits are ignored while busy.
- R5: Without SINGLE_READ, a read continues into the following address and wraps from the last address to 0.
- R6: Special opcode 00 decodes the top two address bits: 00 clears the latch, 11 sets it, 10 erases all. A write after the clear code is ignored.
- R7: Erase-all with the latch set turns every bit of the array to 1.
- R8: With WORD16=1, the address is 6 bits and words are 16 bits. With WORD16=0, the address is 7 bits and words are 8 bits.
- R9: With SINGLE_READ=1, data-out is 0 after the last bit of the addressed word for as long as select stays high.
- R10: With LONG_SPECIAL=1, a special command takes effect only after two extra bits. If select falls before them, the command has no effect.
- R11: 0 bits received in `ST_IDLE` before the start bit are ignored.
- R12: Dropping select in the middle of an instruction abandons it with no change to the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock; input bits are taken on its rising edge |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out, or ready/busy status |
| ready_o | output | 1 | High when no programming cycle is in progress |

## Verification
The bench covers these corner cases:
- Reading the last address while streaming catches a design that fails to wrap the address or stalls at the end of the array.
- Checking the dummy 0 bit catches output that is shifted by one position.
- Writing without enable, after disable, or with the instruction cut short by select falling catches a latch or abort path that corrupts the array.
- On the second configuration, a single-word read must go quiet after 16 bits, and a special command that is missing its two trailing bits must have no effect. A decoder that acted at the address boundary would wrongly enable writes.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_TAIL,
        ST_WDATA,
        ST_RDATA,
        ST_HOLD
    } mw_state_e;

    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_READ    = 2'b10;

    localparam logic [1:0] SP_DISABLE  = 2'b00;
    localparam logic [1:0] SP_ERASEALL = 2'b10;
    localparam logic [1:0] SP_ENABLE   = 2'b11;
endpackage

// File: rtl/mw_pin_sample.sv
module mw_pin_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise
);
    logic sk_q;
    logic sk_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_s <= 1'b0;
            di_s <= 1'b0;
            sk_q <= 1'b0;
            sk_d <= 1'b0;
        end else begin
            cs_s <= cs_i;
            di_s <= di_i;
            sk_q <= sk_i;
            sk_d <= sk_q;
        end
    end

    assign sk_rise = sk_q & ~sk_d;
endmodule

// File: rtl/mw_store.sv
module mw_store #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          erase,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (start) cnt_q <= TW'(CYCLES);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
    parameter int WORD16       = 0,
    parameter int SINGLE_READ  = 0,
    parameter int LONG_SPECIAL = 0,
    parameter int PROG_CYCLES  = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic ready_o
);
    import mw_pkg::*;

    localparam int AW = (WORD16 != 0) ? 6 : 7;
    localparam int DW = (WORD16 != 0) ? 16 : 8;
    localparam int CW = $clog2(DW + 1);

    mw_state_e state_q, state_nxt;

    logic          cs_s, di_s, sk_rise, bit_edge;
    logic          busy;
    logic [CW-1:0] cnt_q;
    logic [1:0]    opc_q;
    logic [AW-1:0] addr_q, rd_addr;
    logic [DW-1:0] shreg_q, rd_data, wr_word;
    logic          wel_q, dout_q, rd_stop_q;
    logic          last_two, last_addr, last_word;
    logic          sp_fire, wr_fire, erase_fire;
    logic [1:0]    sp_code;

    mw_pin_sample u_pins (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
        .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise)
    );

    mw_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(addr_q),
        .wdata(wr_word), .erase(erase_fire), .raddr(rd_addr), .rdata(rd_data)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(wr_fire | erase_fire), .busy(busy)
    );

    assign bit_edge  = sk_rise & cs_s;
    assign last_two  = (cnt_q == CW'(1));
    assign last_addr = (cnt_q == CW'(AW - 1));
    assign last_word = (cnt_q == CW'(DW - 1));
    assign wr_word   = {shreg_q[DW-2:0], di_s};
    assign rd_addr   = (state_q == ST_ADDR) ? {addr_q[AW-2:0], di_s} : addr_q + 1'b1;

    // command execution strobes
    always_comb begin
        sp_code = addr_q[AW-1:AW-2];
        sp_fire = 1'b0;
        if (state_q == ST_ADDR) begin
            sp_code = addr_q[AW-2:AW-3];
            sp_fire = bit_edge && last_addr && (opc_q == OPC_SPECIAL) && (LONG_SPECIAL == 0);
        end else if (state_q == ST_TAIL) begin
            sp_fire = bit_edge && last_two;
        end
        wr_fire    = (state_q == ST_WDATA) && bit_edge && last_word && wel_q;
        erase_fire = sp_fire && (sp_code == SP_ERASEALL) && wel_q;
    end

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:  if (bit_edge && di_s && !busy) state_nxt = ST_OPC;
            ST_OPC:   if (bit_edge && last_two) state_nxt = ST_ADDR;
            ST_ADDR:  if (bit_edge && last_addr) begin
                          if (opc_q == OPC_READ)       state_nxt = ST_RDATA;
                          else if (opc_q == OPC_WRITE) state_nxt = ST_WDATA;
                          else if (opc_q == OPC_SPECIAL && LONG_SPECIAL != 0) state_nxt = ST_TAIL;
                          else                         state_nxt = ST_HOLD;
                      end
            ST_TAIL:  if (bit_edge && last_two) state_nxt = ST_HOLD;
            ST_WDATA: if (bit_edge && last_word) state_nxt = ST_HOLD;
            ST_RDATA: state_nxt = ST_RDATA;
            ST_HOLD:  state_nxt = ST_HOLD;
            default:  state_nxt = ST_IDLE;
        endcase
        if (!cs_s) state_nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            opc_q     <= '0;
            addr_q    <= '0;
            shreg_q   <= '0;
            wel_q     <= 1'b0;
            dout_q    <= 1'b0;
            rd_stop_q <= 1'b0;
        end else begin
            if (!cs_s) begin
                cnt_q <= '0;
            end else if (bit_edge) begin
                if (state_nxt != state_q || (state_q == ST_RDATA && last_word)) cnt_q <= '0;
                else cnt_q <= cnt_q + 1'b1;
            end

            if (sp_fire && sp_code == SP_ENABLE)  wel_q <= 1'b1;
            if (sp_fire && sp_code == SP_DISABLE) wel_q <= 1'b0;

            if (bit_edge) begin
                case (state_q)
                    ST_OPC:   opc_q <= {opc_q[0], di_s};
                    ST_ADDR: begin
                        addr_q <= {addr_q[AW-2:0], di_s};
                        if (last_addr && opc_q == OPC_READ) begin
                            dout_q    <= 1'b0;
                            shreg_q   <= rd_data;
                            rd_stop_q <= 1'b0;
                        end
                    end
                    ST_WDATA: shreg_q <= wr_word;
                    ST_RDATA: begin
                        if (rd_stop_q) begin
                            dout_q <= 1'b0;
                        end else begin
                            dout_q  <= shreg_q[DW-1];
                            shreg_q <= shreg_q << 1;
                            if (last_word) begin
                                if (SINGLE_READ != 0) begin
                                    rd_stop_q <= 1'b1;
                                end else begin
                                    addr_q  <= addr_q + 1'b1;
                                    shreg_q <= rd_data;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // pin outputs
    always_comb begin
        do_o = 1'b0;
        if (cs_s) begin
            if (state_q == ST_RDATA)     do_o = dout_q;
            else if (state_q == ST_IDLE) do_o = ~busy;
        end
        ready_o = ~busy;
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_i,
    input logic              do_o,
    input logic              ready_o,
    input logic              wel,
    input mw_pkg::mw_state_e st
);
    import mw_pkg::*;

    a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_i && $past(!cs_i)) |-> !do_o);

    a_r4_busy_spans: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |=> !ready_o);

    a_r4_busy_locks_decode: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (st == ST_IDLE || st == ST_HOLD));

    a_r6_no_prog_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wel) |-> !$fell(ready_o));
endmodule

bind mw_eeprom mw_eeprom_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .do_o(do_o),
    .ready_o(ready_o), .wel(wel_q), .st(state_q)
);

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CYC = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_a = 1'b0, cs_b = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_a, do_b, ready_a, ready_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int mdl_a [128];
    int mdl_b [64];
    bit wel_a = 0, wel_b = 0;

    int    exp_q [$];
    int    got_q [$];
    string tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom #(.WORD16(0), .SINGLE_READ(0), .LONG_SPECIAL(0), .PROG_CYCLES(CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_a), .sk_i(sk), .di_i(di),
        .do_o(do_a), .ready_o(ready_a)
    );

    mw_eeprom #(.WORD16(1), .SINGLE_READ(1), .LONG_SPECIAL(1), .PROG_CYCLES(CYC)) dut_q (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_b), .sk_i(sk), .di_i(di),
        .do_o(do_b), .ready_o(ready_b)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares captured read words against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() != 0 && exp_q.size() != 0) begin
                int g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(g == e, t, g, e);
            end
        end
    end

    function automatic int aw_of(int t); return (t == 0) ? 7 : 6; endfunction
    function automatic int dw_of(int t); return (t == 0) ? 8 : 16; endfunction
    function automatic logic dout_of(int t); return (t == 0) ? do_a : do_b; endfunction
    function automatic logic rdy_of(int t); return (t == 0) ? ready_a : ready_b; endfunction

    task automatic sel(int t);
        if (t == 0) cs_a = 1'b1; else cs_b = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        cs_a = 1'b0; cs_b = 1'b0; sk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        di = b; sk = 1'b0;
        repeat (4) @(negedge clk);
        sk = 1'b1;
        repeat (4) @(negedge clk);
        sk = 1'b0;
    endtask

    task automatic send_val(int v, int n);
        for (int i = n - 1; i >= 0; i--) send_bit(logic'((v >> i) & 1));
    endtask

    task automatic wait_ready(int t);
        for (int i = 0; i < 2000 && !rdy_of(t); i++) @(negedge clk);
    endtask

    task automatic do_write(int t, int addr, int data);
        sel(t);
        send_val(3'b101, 3);
        send_val(addr, aw_of(t));
        send_val(data, dw_of(t));
        desel();
        if (t == 0 && wel_a) mdl_a[addr] = data;
        if (t == 1 && wel_b) mdl_b[addr] = data;
        wait_ready(t);
    endtask

    task automatic do_special(int t, int code, bit tail);
        sel(t);
        send_val(3'b100, 3);
        send_val(code << (aw_of(t) - 2), aw_of(t));
        if (tail) send_val(0, 2);
        desel();
        if (t == 0 || tail) begin
            if (code == 3) begin
                if (t == 0) wel_a = 1; else wel_b = 1;
            end else if (code == 0) begin
                if (t == 0) wel_a = 0; else wel_b = 0;
            end else if (code == 2) begin
                if (t == 0 && wel_a) foreach (mdl_a[i]) mdl_a[i] = 'hFF;
                if (t == 1 && wel_b) foreach (mdl_b[i]) mdl_b[i] = 'hFFFF;
            end
        end
        wait_ready(t);
    endtask

    task automatic do_read(int t, int addr, int nw, int lead0, string tag);
        int depth;
        depth = 1 << aw_of(t);
        for (int w = 0; w < nw; w++) begin
            int a;
            a = (addr + w) % depth;
            if (t == 1 && w > 0) exp_q.push_back(0);
            else exp_q.push_back((t == 0) ? mdl_a[a] : mdl_b[a]);
            tag_q.push_back(tag);
        end
        sel(t);
        send_val(0, lead0);
        send_val(3'b110, 3);
        send_val(addr, aw_of(t));
        check(dout_of(t) == 1'b0, {tag, " R3 dummy bit"}, int'(dout_of(t)), 0);
        for (int w = 0; w < nw; w++) begin
            int word;
            word = 0;
            for (int b = 0; b < dw_of(t); b++) begin
                send_bit(1'b0);
                word = (word << 1) | int'(dout_of(t));
            end
            got_q.push_back(word);
        end
        desel();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        foreach (mdl_a[i]) mdl_a[i] = 'hFF;
        foreach (mdl_b[i]) mdl_b[i] = 'hFFFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check(do_a == 1'b0, "R1 dout after reset", int'(do_a), 0);
        check(ready_a == 1'b1, "R1 ready after reset", int'(ready_a), 1);

        // R2 write without enable is ignored
        do_write(0, 5, 'hA5);
        do_read(0, 5, 1, 0, "R2 write unlatched");

        // R3/R4 enable, write, busy status
        do_special(0, 3, 0);
        sel(0);
        send_val(3'b101, 3);
        send_val(5, 7);
        send_val('hA5, 8);
        desel();
        mdl_a[5] = 'hA5;
        check(ready_a == 1'b0, "R4 ready low after write", int'(ready_a), 0);
        sel(0);
        check(do_a == 1'b0, "R4 dout busy", int'(do_a), 0);
        send_bit(1'b1);
        check(do_a == 1'b0, "R4 start ignored while busy", int'(do_a), 0);
        wait_ready(0);
        repeat (2) @(negedge clk);
        check(do_a == 1'b1, "R4 dout ready", int'(do_a), 1);
        desel();
        do_read(0, 5, 1, 0, "R3 read back");

        // R5 streaming with wrap
        do_write(0, 127, 'h3C);
        do_write(0, 0, 'h11);
        do_read(0, 127, 3, 0, "R5 sequential wrap");

        // R11 leading zeros before start bit
        do_read(0, 5, 1, 3, "R11 leading zeros");

        // R12 aborted write
        sel(0);
        send_val(3'b101, 3);
        send_val(5, 7);
        send_val('h0, 4);
        desel();
        wait_ready(0);
        check(ready_a == 1'b1, "R12 no programming on abort", int'(ready_a), 1);
        do_read(0, 5, 1, 0, "R12 aborted write");

        // R6 disable then write ignored
        do_special(0, 0, 0);
        do_write(0, 5, 'h00);
        do_read(0, 5, 1, 0, "R6 write after disable");

        // R7 erase all
        do_special(0, 3, 0);
        do_special(0, 2, 0);
        do_read(0, 5, 1, 0, "R7 erase all");
        do_read(0, 126, 3, 0, "R7 erase all tail");

        // R8/R9/R10 second configuration
        do_special(1, 3, 1);
        do_write(1, 3, 'hBEEF);
        do_read(1, 3, 3, 0, "R8 R9 word single read");
        do_special(1, 0, 1);
        do_special(1, 3, 0);
        do_write(1, 4, 'h1234);
        do_read(1, 4, 1, 0, "R10 truncated special");

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule